// File: doc/BRIEF.md
# Multi-Mode Histogram Accumulation Engine

A clocked datapath built around one 1024-word by 24-bit memory and a single adder placed in its read-modify-write path. A 3-bit mode code picks what the shared core does with each active cycle: count pixel occurrences, add a data word into a bin, load or look up table entries, act as a fixed-length delay line, subtract a delayed word from the current one, or turn stored bins into a running cumulative distribution for histogram equalization.

An active-low start qualifier marks the cycles on which the selected mode runs. While it is inactive, the table modes return the word stored at the pixel address, and the delay modes stand still. A one-cycle flash clear empties the whole array and drops everything in flight. Mode codes are expected to change only while the qualifier is inactive.

Top module: `hist_engine`

## Requirements
- R1: After reset or a one-cycle `clr_i` pulse, `dout_o` reads 0 and every memory word reads back as 0; operations in flight at the clear are dropped.
- R2: Mode 0 with `start_n_i` low adds 1 to the bin at `pix_i`; the same bin hit on consecutive cycles counts every hit.
- R3: Mode 1 with `start_n_i` low adds `din_i` to the bin at `pix_i`, and `dout_o` shows the new bin value.
- R4: Mode 2 with `start_n_i` low stores `din_i` at `pix_i`, and `dout_o` shows the stored word.
- R5: With `start_n_i` high in modes 0, 1, 2 or 5, `dout_o` returns the word at `pix_i` and memory is left unchanged.
- R6: A result appears on `dout_o` after the third rising clock edge that follows the cycle its inputs were sampled on, not earlier.
- R7: Mode 3 with `start_n_i` low outputs the `din_i` word given 1024 active cycles earlier, or 0 if fewer than 1024 active cycles have passed since the last clear.
- R8: Mode 4 with `start_n_i` low outputs `din_i` minus the word given 1024 active cycles earlier, modulo 2^24.
- R9: Mode 5 with `start_n_i` low walks addresses upward from 0, one per cycle, writing back and outputting the running sum of bins; each time the qualifier goes inactive in mode 5 the walk restarts at address 0.
- R10: With `start_n_i` high in modes 3 or 4, or in modes 6 and 7, `dout_o` holds its value and memory is not written.
- R11: Bin arithmetic wraps modulo 2^24: 0xFFFFFF plus 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, all activity on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous one-cycle flash clear of the array and pipeline |
| mode_i | input | 3 | Mode code: 0 count, 1 accumulate, 2 table, 3 delay, 4 delay-subtract, 5 cumulative |
| start_n_i | input | 1 | Active-low start qualifier |
| pix_i | input | 10 | Pixel value / bin address |
| din_i | input | 24 | Data word |
| dout_o | output | 24 | Registered result word |

## Verification
A missed forward on a repeated bin shows up as a count short by one as soon as that bin is read, which is three cycles after the read request. A stale valid bit or a pipeline stage that survives a clear puts a nonzero word on `dout_o` on the first read after the clear. A delay or cumulative pointer that is off by one corrupts every later output of the stream, so each streamed sample is compared with its expected value.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_COUNT = 3'd0;
  localparam logic [MODE_W-1:0] MODE_ACCUM = 3'd1;
  localparam logic [MODE_W-1:0] MODE_TABLE = 3'd2;
  localparam logic [MODE_W-1:0] MODE_DELAY = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DSUB  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_CUMUL = 3'd5;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_INC,
    OP_ADD,
    OP_LOAD,
    OP_READ,
    OP_DLY,
    OP_DSUB,
    OP_CUM
  } op_e;
endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_n_i,
  input  logic [ADDR_W-1:0] pix_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              first_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              use_ptr;
  logic              adv;

  always_comb begin
    op_o    = OP_NOP;
    use_ptr = 1'b0;
    case (mode_i)
      MODE_COUNT: op_o = start_n_i ? OP_READ : OP_INC;
      MODE_ACCUM: op_o = start_n_i ? OP_READ : OP_ADD;
      MODE_TABLE: op_o = start_n_i ? OP_READ : OP_LOAD;
      MODE_DELAY: begin
        op_o    = start_n_i ? OP_NOP : OP_DLY;
        use_ptr = 1'b1;
      end
      MODE_DSUB: begin
        op_o    = start_n_i ? OP_NOP : OP_DSUB;
        use_ptr = 1'b1;
      end
      MODE_CUMUL: begin
        op_o    = start_n_i ? OP_READ : OP_CUM;
        use_ptr = !start_n_i;
      end
      default: op_o = OP_NOP;
    endcase
  end

  assign adv     = (op_o == OP_DLY) || (op_o == OP_DSUB) || (op_o == OP_CUM);
  assign addr_o  = use_ptr ? ptr_q : pix_i;
  assign first_o = (op_o == OP_CUM) && (ptr_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_q + 1'b1;
    end else if (mode_i == MODE_CUMUL && start_n_i) begin
      ptr_q <= '0;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv && !clr_i) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1))); // R7

endmodule

// File: rtl/hist_mem.sv
module hist_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              wipe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
    rd_data_o <= mem[rd_addr_i];
  end

  always_ff @(posedge clk_i) begin
    if (wipe_i) begin
      valid_q  <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (we_i) begin
        valid_q[wr_addr_i] <= 1'b1;
      end
      rd_vld_o <= valid_q[rd_addr_i];
    end
  end

  AST_CLR_INVALID: assert property (@(posedge clk_i)
    wipe_i |=> (valid_q == '0)); // R1

  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (wipe_i)
    we_i |=> valid_q[$past(wr_addr_i)]); // R4

endmodule

// File: rtl/hist_alu.sv
module hist_alu
  import hist_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  op_e               op_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_vld_i,
  input  logic              fwd_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              we_o,
  output logic [DATA_W-1:0] new_o,
  output logic [DATA_W-1:0] out_o,
  output logic              out_en_o
);
  logic [DATA_W-1:0] old;
  logic [DATA_W-1:0] addend;

  always_comb begin
    if (fwd_i)         old = fwd_data_i;
    else if (rd_vld_i) old = rd_data_i;
    else               old = '0;
  end

  always_comb begin
    we_o     = 1'b1;
    out_en_o = 1'b1;
    addend   = '0;
    new_o    = old;
    out_o    = old;
    case (op_i)
      OP_INC: begin
        addend = DATA_W'(1);
        new_o  = old + addend;
        out_o  = new_o;
      end
      OP_ADD: begin
        addend = din_i;
        new_o  = old + addend;
        out_o  = new_o;
      end
      OP_LOAD: begin
        new_o = din_i;
        out_o = din_i;
      end
      OP_READ: begin
        we_o = 1'b0;
      end
      OP_DLY: begin
        new_o = din_i;
        out_o = old;
      end
      OP_DSUB: begin
        new_o = din_i;
        out_o = din_i - old;
      end
      OP_CUM: begin
        addend = first_i ? '0 : acc_i;
        new_o  = old + addend;
        out_o  = new_o;
      end
      default: begin
        we_o     = 1'b0;
        out_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_n_i,
  input  logic [ADDR_W-1:0] pix_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic wipe;
  assign wipe = rst_i | clr_i;

  op_e               c_op;
  logic [ADDR_W-1:0] c_addr;
  logic              c_first;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [DATA_W-1:0] s1_din, s2_din;
  logic              s1_first, s2_first;

  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;
  logic              fwd_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [DATA_W-1:0] acc_q;

  logic              alu_we, alu_out_en, mem_we;
  logic [DATA_W-1:0] alu_new, alu_out;

  hist_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (clr_i),
    .mode_i    (mode_i),
    .start_n_i (start_n_i),
    .pix_i     (pix_i),
    .op_o      (c_op),
    .addr_o    (c_addr),
    .first_o   (c_first)
  );

  assign mem_we = alu_we && !wipe;

  hist_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .wipe_i    (wipe),
    .rd_addr_i (s1_addr),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .we_i      (mem_we),
    .wr_addr_i (s2_addr),
    .wr_data_i (alu_new)
  );

  hist_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i       (s2_op),
    .first_i    (s2_first),
    .din_i      (s2_din),
    .rd_data_i  (rd_data),
    .rd_vld_i   (rd_vld),
    .fwd_i      (fwd_q),
    .fwd_data_i (fwd_data_q),
    .acc_i      (acc_q),
    .we_o       (alu_we),
    .new_o      (alu_new),
    .out_o      (alu_out),
    .out_en_o   (alu_out_en)
  );

  always_ff @(posedge clk_i) begin
    if (wipe) begin
      s1_op      <= OP_NOP;
      s2_op      <= OP_NOP;
      s1_addr    <= '0;
      s2_addr    <= '0;
      s1_din     <= '0;
      s2_din     <= '0;
      s1_first   <= 1'b0;
      s2_first   <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
      acc_q      <= '0;
      dout_o     <= '0;
    end else begin
      s1_op      <= c_op;
      s1_addr    <= c_addr;
      s1_din     <= din_i;
      s1_first   <= c_first;
      s2_op      <= s1_op;
      s2_addr    <= s1_addr;
      s2_din     <= s1_din;
      s2_first   <= s1_first;
      fwd_q      <= alu_we && (s1_addr == s2_addr);
      fwd_data_q <= alu_new;
      if (s2_op == OP_CUM) begin
        acc_q <= alu_new;
      end
      if (alu_out_en) begin
        dout_o <= alu_out;
      end
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i)
    clr_i |=> (dout_o == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (s2_op == OP_NOP && !clr_i) |=> $stable(dout_o)); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (s2_op == OP_NOP || s2_op == OP_READ) |-> !mem_we); // R5

endmodule

// File: tb/hist_engine_tb.sv
module hist_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        clr_i = 1'b0;
  logic [2:0]  mode_i = 3'd3;
  logic        start_n_i = 1'b1;
  logic [9:0]  pix_i = '0;
  logic [23:0] din_i = '0;
  logic [23:0] dout_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  hist_engine u_dut (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .mode_i(mode_i),
    .start_n_i(start_n_i), .pix_i(pix_i), .din_i(din_i), .dout_o(dout_o)
  );

  // {mode, start_n, pix, din, expected}
  localparam logic [61:0] VEC [11] = '{
    {3'd2, 1'b0, 10'd5, 24'h123456, 24'h123456}, // R4 table load
    {3'd2, 1'b1, 10'd5, 24'h000000, 24'h123456}, // R5 lookup
    {3'd0, 1'b0, 10'd5, 24'h000000, 24'h123457}, // R2 count
    {3'd1, 1'b0, 10'd5, 24'h000010, 24'h123467}, // R3 accumulate
    {3'd5, 1'b1, 10'd5, 24'h000000, 24'h123467}, // R5 lookup in mode 5
    {3'd0, 1'b1, 10'd6, 24'h000000, 24'h000000}, // R1 untouched bin
    {3'd2, 1'b0, 10'd7, 24'hFFFFFF, 24'hFFFFFF}, // R4
    {3'd0, 1'b0, 10'd7, 24'h000000, 24'h000000}, // R11 count wrap
    {3'd1, 1'b0, 10'd6, 24'hFFFFFF, 24'hFFFFFF}, // R3
    {3'd1, 1'b0, 10'd6, 24'h000002, 24'h000001}, // R11 add wrap
    {3'd1, 1'b1, 10'd6, 24'h000000, 24'h000001}  // R5
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic sn, input logic [9:0] p, input logic [23:0] d);
    mode_i = m; start_n_i = sn; pix_i = p; din_i = d;
  endtask

  task automatic idle();
    drive(3'd3, 1'b1, 10'd0, 24'd0);
  endtask

  task automatic apply(input logic [2:0] m, input logic sn, input logic [9:0] p, input logic [23:0] d);
    @(negedge clk_i); drive(m, sn, p, d);
    @(negedge clk_i); idle();
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic flash_clear();
    @(negedge clk_i); idle(); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] prev;
    repeat (4) @(negedge clk_i);
    rst_i = 1'b0;
    check("R1 reset dout", dout_o, 24'd0);
    apply(3'd2, 1'b1, 10'd5, 24'd0);
    check("R1 reset bin", dout_o, 24'd0);

    foreach (VEC[i]) begin
      apply(VEC[i][61:59], VEC[i][58], VEC[i][57:48], VEC[i][47:24]);
      check($sformatf("R2-5,R11 vec%0d", i), dout_o, VEC[i][23:0]);
    end

    // R10: idle modes hold output and leave memory alone
    prev = dout_o;
    apply(3'd7, 1'b0, 10'd6, 24'h55);
    check("R10 mode7 hold", dout_o, prev);
    apply(3'd4, 1'b1, 10'd6, 24'h55);
    check("R10 dsub idle hold", dout_o, prev);
    apply(3'd0, 1'b1, 10'd6, 24'd0);
    check("R10 bin untouched", dout_o, 24'd1);

    // R6: latency of three edges
    apply(3'd0, 1'b1, 10'd40, 24'd0);
    @(negedge clk_i); drive(3'd2, 1'b0, 10'd20, 24'h0ABCDE);
    @(negedge clk_i); idle();
    @(negedge clk_i);
    check("R6 not early", dout_o, 24'd0);
    @(negedge clk_i);
    check("R6 on time", dout_o, 24'h0ABCDE);

    // R1: flash clear
    flash_clear();
    check("R1 clear dout", dout_o, 24'd0);
    apply(3'd0, 1'b1, 10'd5, 24'd0);
    check("R1 clear bin5", dout_o, 24'd0);

    // R2: back-to-back hits on one bin
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      drive(3'd0, 1'b0, (k == 3) ? 10'd3 : 10'd9, 24'd0);
    end
    @(negedge clk_i); idle();
    repeat (3) @(negedge clk_i);
    apply(3'd0, 1'b1, 10'd9, 24'd0);
    check("R2 repeated bin", dout_o, 24'd4);
    apply(3'd0, 1'b1, 10'd3, 24'd0);
    check("R2 other bin", dout_o, 24'd1);

    // R7: delay line
    flash_clear();
    for (int k = 0; k < 1032 + 3; k++) begin
      @(negedge clk_i);
      if (k >= 3) begin
        int j;
        j = k - 3;
        check("R7 delay", dout_o, (j >= 1024) ? 24'(j - 1024 + 1) : 24'd0);
      end
      if (k < 1032) drive(3'd3, 1'b0, 10'd0, 24'(k + 1));
      else idle();
    end

    // R8: delay and subtract
    flash_clear();
    for (int k = 0; k < 1032 + 3; k++) begin
      @(negedge clk_i);
      if (k >= 3) begin
        int j;
        j = k - 3;
        check("R8 dsub", dout_o, (j >= 1024) ? 24'd3072 : 24'(3 * j + 5));
      end
      if (k < 1032) drive(3'd4, 1'b0, 10'd0, 24'(3 * k + 5));
      else idle();
    end

    // R9: cumulative walk
    flash_clear();
    for (int b = 0; b < 4; b++) apply(3'd2, 1'b0, 10'(b), 24'(b + 1));
    for (int k = 0; k < 1024 + 3; k++) begin
      @(negedge clk_i);
      if (k >= 3) begin
        int s;
        s = k - 3;
        check("R9 cumulative", dout_o,
              (s == 0) ? 24'd1 : (s == 1) ? 24'd3 : (s == 2) ? 24'd6 : 24'd10);
      end
      if (k < 1024) drive(3'd5, 1'b0, 10'd0, 24'd0);
      else idle();
    end
    apply(3'd5, 1'b1, 10'd1023, 24'd0);
    check("R9 last bin", dout_o, 24'd10);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      if (k == 4) check("R9 second step", dout_o, 24'd4);
      if (k == 6) check("R9 restart at 0", dout_o, 24'd1);
      if (k < 2 || k == 3) drive(3'd5, 1'b0, 10'd0, 24'd0);
      else if (k == 2) drive(3'd5, 1'b1, 10'd0, 24'd0);
      else idle();
    end
    apply(3'd0, 1'b1, 10'd1, 24'd0);
    check("R9 bin1 after restart", dout_o, 24'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule